// File: doc/BRIEF.md
# Split-Load Countdown Watchdog Timer

This block is a 32-bit watchdog counter that counts down once per clock of a 10 MHz timebase. Software writes the reload value as two 16-bit halves over one narrow write port. The low half only goes into a holding register. Writing the high half moves the joined 32-bit value into the counter in one step, so the counter never holds a value with only one half updated.

Once enabled, the counter decrements on every clock. The clock edge that takes the count from one to zero sets a level interrupt toward the host. On that same edge it sends a single-cycle event pulse to the output manager, which then drives its outputs to their safety values. At zero the counter stops and the interrupt stays asserted until software clears it. Software keeps the watchdog from expiring by rewriting the load value, which also restarts the countdown. Software can disable the counter, and the count then freezes where it is.

Top module: `wdt_split_load`

## Requirements
- R1: After a synchronous reset, count is 0, irq is 0, safe_evt is 0 and running is 0, so the watchdog starts disabled.
- R2: A write with wr_en=1 and wr_hi=0 stores wr_data as the pending low half and leaves count unchanged.
- R3: A write with wr_en=1 and wr_hi=1 sets count on that clock edge to {wr_data, pending low half}, with the high half in bits 31:16. The pending low half is kept for later high-half writes.
- R4: While running is 0 and no high-half write occurs, count holds its value.
- R5: While running is 1 and count is nonzero, count drops by exactly one on each clock edge that has no high-half write.
- R6: The edge that takes count from 1 to 0 sets irq to 1 and drives safe_evt high for exactly one cycle.
- R7: At zero, count stays 0, irq stays 1, and safe_evt produces no further pulses.
- R8: irq_clr=1 clears irq on the next edge, and irq stays 0 while count remains 0.
- R9: A high-half write clears irq and restarts the countdown from the new value, even while the counter is running. It takes priority over the decrement in that cycle.
- R10: When irq_clr is asserted in the same cycle as the 1-to-0 expiry, the expiry wins and irq becomes 1.
- R11: Loading a value of zero raises neither irq nor safe_evt.
- R12: en_we=1 copies en_data into the enable state, which shows on running after that edge. The counter acts on the new setting from the following edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock (10 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load-value write strobe |
| wr_hi | input | 1 | 0: write the low half, 1: write the high half and commit |
| wr_data | input | 16 | Half of the load value |
| en_we | input | 1 | Enable write strobe |
| en_data | input | 1 | New enable value |
| irq_clr | input | 1 | Interrupt clear strobe |
| count | output | 32 | Present counter value |
| running | output | 1 | Enable state |
| irq | output | 1 | Level interrupt to the host |
| safe_evt | output | 1 | One-cycle pulse to the safety output manager |

## Verification
The countdown is run from a small load value down to zero and past it. This tells a decrement by exactly one apart from a skip, and a counter that stops at zero from one that wraps. Writes of only the low half, of both halves, and of the high half alone show whether the commit happens only on the high half and whether the pending low half is kept between writes. Clears that coincide with expiry, reloads while the interrupt is pending, a zero load and a mid-count disable test the priority rules. They also show whether anything other than a decrement to zero can raise the interrupt.

// File: rtl/wdt_split_pkg.sv
package wdt_split_pkg;

    localparam int unsigned HALF_W_DEF = 16;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_DEC  = 2'd2
    } cnt_act_e;

    // A reload outranks the decrement; a stopped or empty counter holds.
    function automatic cnt_act_e pick_action(input logic load,
                                             input logic en,
                                             input logic nonzero);
        if (load)
            return ACT_LOAD;
        if (en && nonzero)
            return ACT_DEC;
        return ACT_HOLD;
    endfunction

endpackage

// File: rtl/wdt_half_stage.sv
module wdt_half_stage #(
    parameter int unsigned HALF_W = 16,
    localparam int unsigned FULL_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wr_data,
    output logic              load_o,
    output logic [FULL_W-1:0] load_val_o
);
    logic [HALF_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst)
            lo_q <= '0;
        else if (wr_en && !wr_hi)
            lo_q <= wr_data;
    end

    assign load_o     = wr_en && wr_hi;
    assign load_val_o = {wr_data, lo_q};
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter
    import wdt_split_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             en_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;
    cnt_act_e         act;

    always_comb begin
        act      = pick_action(load_i, en_i, cnt_q != '0);
        expire_o = (act == ACT_DEC) && (cnt_q == CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            case (act)
                ACT_LOAD: cnt_q <= load_val_i;
                ACT_DEC:  cnt_q <= cnt_q - CNT_W'(1);
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/wdt_irq_latch.sv
module wdt_irq_latch (
    input  logic clk,
    input  logic rst,
    input  logic expire_i,
    input  logic clr_i,
    input  logic reload_i,
    output logic irq_o,
    output logic evt_o
);
    logic irq_q;
    logic evt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
            evt_q <= 1'b0;
        end else begin
            evt_q <= expire_i;
            if (expire_i)
                irq_q <= 1'b1;
            else if (clr_i || reload_i)
                irq_q <= 1'b0;
        end
    end

    assign irq_o = irq_q;
    assign evt_o = evt_q;
endmodule

// File: rtl/wdt_split_load.sv
module wdt_split_load
    import wdt_split_pkg::*;
#(
    parameter int unsigned HALF_W = HALF_W_DEF,
    localparam int unsigned CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              en_we,
    input  logic              en_data,
    input  logic              irq_clr,
    output logic [CNT_W-1:0]  count,
    output logic              running,
    output logic              irq,
    output logic              safe_evt
);
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expire;
    logic             en_q;

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else if (en_we)
            en_q <= en_data;
    end

    wdt_half_stage #(.HALF_W(HALF_W)) u_stage (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_hi      (wr_hi),
        .wr_data    (wr_data),
        .load_o     (load),
        .load_val_o (load_val)
    );

    wdt_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load),
        .load_val_i (load_val),
        .en_i       (en_q),
        .count_o    (count),
        .expire_o   (expire)
    );

    wdt_irq_latch u_irq (
        .clk      (clk),
        .rst      (rst),
        .expire_i (expire),
        .clr_i    (irq_clr),
        .reload_i (load),
        .irq_o    (irq),
        .evt_o    (safe_evt)
    );

    assign running = en_q;
endmodule

// File: rtl/wdt_split_load_chk.sv
module wdt_split_load_chk #(
    parameter int unsigned HALF_W = 16,
    localparam int unsigned CNT_W = 2 * HALF_W
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              wr_hi,
    input logic [HALF_W-1:0] wr_data,
    input logic              irq_clr,
    input logic [CNT_W-1:0]  count,
    input logic              running,
    input logic              irq,
    input logic              safe_evt
);
    a_r5_step_down: assert property (@(posedge clk) disable iff (rst)
        (running && count != '0 && !(wr_en && wr_hi))
        |=> count == $past(count) - CNT_W'(1));

    a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!running && !(wr_en && wr_hi)) |=> $stable(count));

    a_r2_low_only: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_hi && !running) |=> $stable(count));

    a_r3_high_commit: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_hi) |=> count[CNT_W-1:HALF_W] == $past(wr_data));

    a_r9_reload_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_hi) |=> !irq);

    a_r6_evt_with_irq: assert property (@(posedge clk) disable iff (rst)
        safe_evt |-> (irq && count == '0));

    a_r6_evt_single: assert property (@(posedge clk) disable iff (rst)
        safe_evt |=> !safe_evt);

    a_r8_clear_at_zero: assert property (@(posedge clk) disable iff (rst)
        (irq_clr && count == '0) |=> !irq);

    a_r7_stay_zero: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && !(wr_en && wr_hi)) |=> count == '0);
endmodule

bind wdt_split_load wdt_split_load_chk #(.HALF_W(HALF_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_hi    (wr_hi),
    .wr_data  (wr_data),
    .irq_clr  (irq_clr),
    .count    (count),
    .running  (running),
    .irq      (irq),
    .safe_evt (safe_evt)
);

// File: tb/wdt_split_load_tb.sv
`timescale 1ns/1ps
module wdt_split_load_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_hi = 1'b0;
    logic [15:0] wr_data = '0;
    logic        en_we = 1'b0;
    logic        en_data = 1'b0;
    logic        irq_clr = 1'b0;
    logic [31:0] count;
    logic        running;
    logic        irq;
    logic        safe_evt;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    wdt_split_load u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
        .en_we(en_we), .en_data(en_data), .irq_clr(irq_clr),
        .count(count), .running(running), .irq(irq), .safe_evt(safe_evt)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_half(input logic hi, input logic [15:0] d);
        wr_en = 1'b1; wr_hi = hi; wr_data = d;
        step();
        wr_en = 1'b0; wr_hi = 1'b0;
    endtask

    task automatic set_enable(input logic v);
        en_we = 1'b1; en_data = v;
        step();
        en_we = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 count", count, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 safe_evt", {31'd0, safe_evt}, 32'd0);
        check("R1 running", {31'd0, running}, 32'd0);
    endtask

    task automatic t_halves();
        write_half(1'b0, 16'h1234);
        check("R2 low write leaves count", count, 32'd0);
        write_half(1'b1, 16'hABCD);
        check("R3 joined load", count, 32'hABCD1234);
        write_half(1'b1, 16'h0001);
        check("R3 pending low reused", count, 32'h00011234);
        step(); step();
        check("R4 disabled holds", count, 32'h00011234);
    endtask

    task automatic t_expire();
        write_half(1'b0, 16'd3);
        write_half(1'b1, 16'd0);
        check("R3 small load", count, 32'd3);
        set_enable(1'b1);
        check("R12 running set", {31'd0, running}, 32'd1);
        check("R12 no step on enable edge", count, 32'd3);
        step();
        check("R5 first decrement", count, 32'd2);
        step();
        check("R5 second decrement", count, 32'd1);
        check("R6 no irq before zero", {31'd0, irq}, 32'd0);
        step();
        check("R6 zero reached", count, 32'd0);
        check("R6 irq raised", {31'd0, irq}, 32'd1);
        check("R6 event pulse", {31'd0, safe_evt}, 32'd1);
        step();
        check("R6 event one cycle", {31'd0, safe_evt}, 32'd0);
        step();
        check("R7 stays zero", count, 32'd0);
        check("R7 irq holds", {31'd0, irq}, 32'd1);
    endtask

    task automatic t_clear();
        irq_clr = 1'b1;
        step();
        irq_clr = 1'b0;
        check("R8 irq cleared", {31'd0, irq}, 32'd0);
        step(); step();
        check("R8 irq stays low", {31'd0, irq}, 32'd0);
        check("R8 count still zero", count, 32'd0);
    endtask

    task automatic t_clear_race();
        write_half(1'b0, 16'd2);
        write_half(1'b1, 16'd0);
        check("R9 reload while running", count, 32'd2);
        step();
        check("R5 decrement to one", count, 32'd1);
        irq_clr = 1'b1;
        step();
        irq_clr = 1'b0;
        check("R10 expiry beats clear", {31'd0, irq}, 32'd1);
        check("R10 event still fires", {31'd0, safe_evt}, 32'd1);
    endtask

    task automatic t_reload();
        write_half(1'b0, 16'd4);
        check("R9 irq kept before high half", {31'd0, irq}, 32'd1);
        write_half(1'b1, 16'd0);
        check("R9 reload value", count, 32'd4);
        check("R9 reload clears irq", {31'd0, irq}, 32'd0);
        step();
        check("R9 countdown restarted", count, 32'd3);
    endtask

    task automatic t_disable();
        set_enable(1'b0);
        check("R12 running cleared", {31'd0, running}, 32'd0);
        check("R12 old enable used on its edge", count, 32'd2);
        step(); step(); step();
        check("R4 count frozen", count, 32'd2);
    endtask

    task automatic t_zero_load();
        set_enable(1'b1);
        write_half(1'b0, 16'd0);
        write_half(1'b1, 16'd0);
        check("R11 zero load count", count, 32'd0);
        check("R11 no event", {31'd0, safe_evt}, 32'd0);
        step(); step();
        check("R11 no irq", {31'd0, irq}, 32'd0);
        check("R11 no late event", {31'd0, safe_evt}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_halves();
        t_expire();
        t_clear();
        t_clear_race();
        t_reload();
        t_disable();
        t_zero_load();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=hung expected=done");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule